// File: doc/BRIEF.md
# Receiver Error Flag and Enable Register Block

This block keeps the sticky error flags of a serial receiver (parity error, framing error and overrun) together with the receiver-enable state. The receiver datapath lies outside the block. It is represented by three single-cycle error strobes. A strobe is recorded only while its detection enable bit in the control register is on.

Software changes the flags and the receiver enable through a write-only command register. Each bit in that register performs one action: it sets or clears the receiver enable, or it clears one flag. Because of this, software never needs a read-modify-write sequence.

The block drives a level error interrupt while any flag is set. Register reads are registered, so read data appears one cycle after the read strobe.

Top module: `rx_err_status`

## Requirements
- R1: After synchronous reset, the control and status registers read as zero, `rx_enabled` is low and `err_irq` is low.
- R2: The control register is at offset 0x10. Only the following bits are stored, and each reads back as written: bit 17 (framing detect), bit 18 (parity detect), bit 19 (overrun detect) and bit 20 (transmit overrun detect). All other bits read zero.
- R3: The status register is at offset 0x14 and is read-only. Bit 15 is receiver enable, bit 16 is the parity flag, bit 17 is the framing flag and bit 19 is the overrun flag. All other bits read zero. A write to 0x14 changes nothing.
- R4: An error strobe sets its flag at the next clock edge only when its detection enable is on. When the enable is off, the strobe leaves the flag at zero.
- R5: A flag stays set until software writes a 1 to its clear bit at offset 0x18: bit 2 for parity, bit 3 for framing, bit 5 for overrun. Clearing one flag leaves the other flags unchanged.
- R6: When an enabled error strobe and a clear of the same flag occur in the same cycle, the flag ends up set.
- R7: Writing bit 1 at offset 0x18 turns the receiver enable on. Writing bit 0 turns it off. Writing both turns it off. The `rx_enabled` output follows the status bit.
- R8: Reading offset 0x18 returns zero, and the read does not change any state.
- R9: `err_irq` is high exactly when at least one error flag is set. It changes in the same cycle as the flags.
- R10: An overrun is flagged independently of the other errors. Strobes that arrive together each set their own enabled flag, and an overrun neither masks nor changes a parity or framing flag.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd`. Any unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| par_err_stb | input | 1 | Parity error pulse from receiver |
| frm_err_stb | input | 1 | Framing error pulse from receiver |
| ovr_err_stb | input | 1 | Overrun pulse from receiver |
| rx_enabled | output | 1 | Receiver enable state |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of design error:

- Same-cycle collisions. A flag that is struck and cleared in the same cycle must stay set; a design that lets the clear win would silently drop an error. A receiver-enable write with both the set and the clear bit must leave the receiver off; a design that gives the set bit priority would do the opposite.
- Gating. Strobes that arrive while their detection enable is off must leave the status unchanged. A design that latches ungated strobes, or that tests the wrong control bit, would show the wrong flag.
- Independence. Simultaneous strobes, and clears of a single flag, must touch only the intended flags. A design that clears all flags at once or merges them would show up in the status word.
- Inert accesses. Writes to the status offset, reads of the command offset and reads of unmapped offsets are checked for zero data and unchanged state.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned F_PAR  = 0;
  localparam int unsigned F_FRM  = 1;
  localparam int unsigned F_OVR  = 2;

  // bit positions, indexed by flag number
  localparam int unsigned STAT_BIT [FLAG_N] = '{16, 17, 19};
  localparam int unsigned DET_BIT  [FLAG_N] = '{18, 17, 19};
  localparam int unsigned CLR_BIT  [FLAG_N] = '{2, 3, 5};

  localparam int unsigned RXEN_STAT_BIT = 15;
  localparam int unsigned RXEN_CLR_BIT  = 0;
  localparam int unsigned RXEN_SET_BIT  = 1;
  localparam int unsigned TXOVR_DET_BIT = 20;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/asc_addr_dec.sv
module asc_addr_dec
  import rxst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h18
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == CTRL_OFS)      sel = SEL_CTRL;
    else if (addr == STAT_OFS) sel = SEL_STAT;
    else if (addr == CMD_OFS)  sel = SEL_CMD;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/asc_ctrl_reg.sv
module asc_ctrl_reg #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/asc_flag_cell.sv
module asc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic det_en,
  input  logic evt,
  input  logic clr,
  output logic d,
  output logic q
);
  // a qualified event takes priority over a software clear
  always_comb begin
    if (evt && det_en) d = 1'b1;
    else if (clr)      d = 1'b0;
    else               d = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/asc_rxen_cell.sv
module asc_rxen_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);
  // clear has priority over set
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (clr_req) q <= 1'b0;
    else if (set_req) q <= 1'b1;
  end
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rxst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              par_err_stb,
  input  logic              frm_err_stb,
  input  logic              ovr_err_stb,
  output logic              rx_enabled,
  output logic              err_irq
);
  function automatic logic [DATA_W-1:0] ctrl_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(FLAG_N); i++) m[DET_BIT[i]] = 1'b1;
    m[TXOVR_DET_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask_f();

  reg_sel_e          sel;
  logic              wr_ctrl;
  logic              wr_cmd;
  logic [DATA_W-1:0] ctrl_q;
  logic [FLAG_N-1:0] evt;
  logic [FLAG_N-1:0] det_en;
  logic [FLAG_N-1:0] clr_req;
  logic [FLAG_N-1:0] flag_d;
  logic [FLAG_N-1:0] flag_q;
  logic              rx_en_q;
  logic [DATA_W-1:0] stat_w;

  asc_addr_dec #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS),
    .CMD_OFS (CMD_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_cmd  = bus_wr && (sel == SEL_CMD);

  asc_ctrl_reg #(
    .DATA_W(DATA_W),
    .MASK  (CTRL_MASK)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ctrl),
    .wdata(bus_wdata),
    .q    (ctrl_q)
  );

  assign evt[F_PAR] = par_err_stb;
  assign evt[F_FRM] = frm_err_stb;
  assign evt[F_OVR] = ovr_err_stb;

  for (genvar g = 0; g < int'(FLAG_N); g++) begin : g_flag
    assign det_en[g]  = ctrl_q[DET_BIT[g]];
    assign clr_req[g] = wr_cmd && bus_wdata[CLR_BIT[g]];

    asc_flag_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .det_en(det_en[g]),
      .evt   (evt[g]),
      .clr   (clr_req[g]),
      .d     (flag_d[g]),
      .q     (flag_q[g])
    );
  end

  asc_rxen_cell u_rxen (
    .clk    (clk),
    .rst    (rst),
    .set_req(wr_cmd && bus_wdata[RXEN_SET_BIT]),
    .clr_req(wr_cmd && bus_wdata[RXEN_CLR_BIT]),
    .q      (rx_en_q)
  );

  assign rx_enabled = rx_en_q;

  // interrupt registered from next-state flags, aligned with flag_q
  always_ff @(posedge clk) begin
    if (rst) err_irq <= 1'b0;
    else     err_irq <= |flag_d;
  end

  always_comb begin
    stat_w = '0;
    stat_w[RXEN_STAT_BIT] = rx_en_q;
    for (int i = 0; i < int'(FLAG_N); i++) stat_w[STAT_BIT[i]] = flag_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL: bus_rdata <= ctrl_q;
        SEL_STAT: bus_rdata <= stat_w;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_err_status_chk.sv
module rx_err_status_chk
  import rxst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              par_err_stb,
  input logic              frm_err_stb,
  input logic              ovr_err_stb,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [FLAG_N-1:0] flag_q,
  input logic              rx_enabled,
  input logic              err_irq
);
  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == CMD_OFS);

  p_irq_any_r9: assert property (@(posedge clk) disable iff (rst)
    err_irq == (|flag_q));

  p_det_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[F_FRM] && !(frm_err_stb && ctrl_q[DET_BIT[F_FRM]]))
    |=> !flag_q[F_FRM]);

  p_clear_frm_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[CLR_BIT[F_FRM]] && !(frm_err_stb && ctrl_q[DET_BIT[F_FRM]]))
    |=> !flag_q[F_FRM]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (par_err_stb && ctrl_q[DET_BIT[F_PAR]]) |=> flag_q[F_PAR]);

  p_rxen_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[RXEN_CLR_BIT]) |=> !rx_enabled);

  p_rxen_set_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[RXEN_SET_BIT] && !bus_wdata[RXEN_CLR_BIT]) |=> rx_enabled);

  p_cmd_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CMD_OFS) |=> (bus_rdata == '0));

  p_ovr_indep_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr_err_stb && ctrl_q[DET_BIT[F_OVR]]) |=> flag_q[F_OVR]);
endmodule

bind rx_err_status rx_err_status_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CMD_OFS(CMD_OFS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .par_err_stb(par_err_stb),
  .frm_err_stb(frm_err_stb),
  .ovr_err_stb(ovr_err_stb),
  .ctrl_q     (ctrl_q),
  .flag_q     (flag_q),
  .rx_enabled (rx_enabled),
  .err_irq    (err_irq)
);

// File: tb/rx_err_status_bench.sv
module rx_err_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_CMD  = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        par_err_stb = 1'b0;
  logic        frm_err_stb = 1'b0;
  logic        ovr_err_stb = 1'b0;
  logic        rx_enabled;
  logic        err_irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_status u_rx_err_status (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .par_err_stb(par_err_stb),
    .frm_err_stb(frm_err_stb),
    .ovr_err_stb(ovr_err_stb),
    .rx_enabled (rx_enabled),
    .err_irq    (err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe(input logic p, input logic f, input logic o);
    @(negedge clk);
    par_err_stb = p; frm_err_stb = f; ovr_err_stb = o;
    @(negedge clk);
    par_err_stb = 1'b0; frm_err_stb = 1'b0; ovr_err_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
    rd(A_STAT, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, err_irq}, 32'h0);
    chk("R1 rx_enabled after reset", {31'b0, rx_enabled}, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 ctrl stored bits only", d, 32'h001E_0000);
    wr(A_CTRL, 32'h0010_0000);
    rd(A_CTRL, d); chk("R2 tx overrun detect bit", d, 32'h0010_0000);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R11 read latency ctrl", d, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    strobe(1'b1, 1'b1, 1'b1);
    rd(A_STAT, d); chk("R4 strobes with detect off", d, 32'h0);
    chk("R9 irq low with no flags", {31'b0, err_irq}, 32'h0);
    wr(A_CTRL, 32'h0002_0000);
    strobe(1'b1, 1'b1, 1'b1);
    rd(A_STAT, d); chk("R4 only framing detect on", d, 32'h0002_0000);
    chk("R9 irq on framing", {31'b0, err_irq}, 32'h1);
    wr(A_CMD, 32'h8);
    rd(A_STAT, d); chk("R5 framing cleared", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(A_CTRL, 32'h000E_0000);
    strobe(1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R5 all flags sticky", d, 32'h000B_0000);
    wr(A_CMD, 32'h4);
    rd(A_STAT, d); chk("R5 clear parity only", d, 32'h000A_0000);
    chk("R9 irq still high", {31'b0, err_irq}, 32'h1);
    wr(A_CMD, 32'h28);
    rd(A_STAT, d); chk("R5 clear framing and overrun", d, 32'h0);
    chk("R9 irq low after clears", {31'b0, err_irq}, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CMD; bus_wdata = 32'h4; par_err_stb = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; par_err_stb = 1'b0;
    chk("R9 irq same cycle as flag", {31'b0, err_irq}, 32'h1);
    rd(A_STAT, d); chk("R6 set beats clear", d, 32'h0001_0000);
    wr(A_CMD, 32'h4);
    rd(A_STAT, d); chk("R5 parity cleared", d, 32'h0);
  endtask

  task automatic t_rxen();
    logic [31:0] d;
    wr(A_CMD, 32'h2);
    rd(A_STAT, d); chk("R7 rx enable set", d, 32'h0000_8000);
    chk("R7 rx_enabled high", {31'b0, rx_enabled}, 32'h1);
    wr(A_CMD, 32'h3);
    rd(A_STAT, d); chk("R7 clear wins over set", d, 32'h0);
    chk("R7 rx_enabled low", {31'b0, rx_enabled}, 32'h0);
    wr(A_CMD, 32'h2);
    wr(A_CMD, 32'h1);
    chk("R7 rx enable cleared", {31'b0, rx_enabled}, 32'h0);
  endtask

  task automatic t_cmd_read();
    logic [31:0] d;
    wr(A_CMD, 32'h2);
    rd(A_CMD, d); chk("R8 command offset reads zero", d, 32'h0);
    chk("R8 read leaves rx enable", {31'b0, rx_enabled}, 32'h1);
    rd(A_STAT, d); chk("R8 status after command read", d, 32'h0000_8000);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    strobe(1'b1, 1'b0, 1'b1);
    rd(A_STAT, d); chk("R10 overrun and parity together", d, 32'h0009_8000);
    strobe(1'b0, 1'b0, 1'b1);
    rd(A_STAT, d); chk("R10 overrun leaves parity", d, 32'h0009_8000);
    wr(A_CMD, 32'h2C);
    wr(A_CTRL, 32'h0008_0000);
    strobe(1'b0, 1'b1, 1'b1);
    rd(A_STAT, d); chk("R10 overrun only enable", d, 32'h0008_8000);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R3 status write ignored", d, 32'h0008_8000);
    rd(A_CTRL, d); chk("R3 status write leaves ctrl", d, 32'h0008_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h1C, d); chk("R11 unmapped 0x1C reads zero", d, 32'h0);
    rd(8'h00, d); chk("R11 unmapped 0x00 reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_gate();
    t_sticky();
    t_set_wins();
    t_rxen();
    t_cmd_read();
    t_overrun();
    t_status_ro();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule